// File: doc/BRIEF.md
# Tone-Pair Steering Timer and Code Latch

This block sits behind a dual-tone detector. The detector supplies a per-cycle "pair present" flag and the row and column indices of the pair. The block decides when that pair counts as a keypress and then turns it into a 4-bit key code. An up/down guard counter replaces the analogue time constant that usually sets the tone-duration and inter-digit-pause checks. It counts up while the flag is high and down while it is low. A digit is accepted when the counter reaches the acquisition limit. The block is freed for the next digit only after the counter has run back down over the pause limit.

When a pair is accepted, its code is written into a holding register. A strobe output rises a fixed settling time after that write and falls when the pause has been validated. An inhibit input blocks acceptance of the fourth-column keys. An output-enable input gates the code bus. A power-down input clears the timing state and holds the strobe low. Both guard limits are run-time inputs, so the duration and pause requirements can be tuned.

Top module: `dtmf_steer`

## Requirements
- R1: With the guard counter at zero, a pair is accepted on the clock edge that samples `early_i` high for the `acq_lim_i`-th consecutive time, and the code appears on `q_o` after that edge. A run of `acq_lim_i`-1 high cycles followed by low cycles is never accepted. A limit value of 0 acts as 1.
- R2: Before acceptance, a low cycle on `early_i` decrements the guard count by one and does not clear it. With a limit of 4, the pattern 3 high, 1 low, 2 high is accepted on the last high cycle.
- R3: After acceptance, a run of `early_i` low cycles shorter than `pause_lim_i` leaves `std_o` high. While the current digit is held, no other pair is accepted, whatever the row and column inputs do.
- R4: `std_o` is low on the edge that writes the code and on the edge after it. It rises on the second edge after the write.
- R5: After acceptance, `std_o` falls on the edge that samples `early_i` low for the `pause_lim_i`-th consecutive time. A limit value of 0 acts as 1.
- R6: Rows 0 to 3 and columns 0 to 3 address the key grid 1 2 3 A / 4 5 6 B / 7 8 9 C / * 0 # D. Keys 1 to 9 encode as their binary value. Key 0 encodes as 10, * as 11, # as 12, A as 13, B as 14, C as 15 and D as 0.
- R7: While `inhibit_i` is high, a pair with column index 3 is never accepted. `q_o` keeps the previous code and `std_o` stays low.
- R8: `q_oe_o` follows `out_en_i`. `q_o` shows the latched code while `out_en_i` is high and is all zero while it is low.
- R9: While `pwr_down_i` is high, `std_o` is low from the next edge and no pair is accepted. After release, acceptance takes a full `acq_lim_i` high cycles counted from the first edge without power-down. The latched code is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_down_i | input | 1 | Power-down, active high |
| early_i | input | 1 | Pair-present flag from the detector |
| row_i | input | 2 | Low-group row index 0..3 |
| col_i | input | 2 | High-group column index 0..3 |
| inhibit_i | input | 1 | Blocks column-3 keys when high |
| acq_lim_i | input | CNT_W | Acquisition guard, in cycles |
| pause_lim_i | input | CNT_W | Pause guard, in cycles |
| out_en_i | input | 1 | Code bus enable |
| q_o | output | 4 | Latched key code, zero when disabled |
| q_oe_o | output | 1 | Bus drive enable |
| std_o | output | 1 | Delayed steering strobe |

## Verification
The code is due after the edge that samples the `acq_lim_i`-th consecutive high flag. The strobe follows two edges later. The strobe falls after the edge that samples the `pause_lim_i`-th low flag. The bus gating is combinational. The bench drives on falling edges and counts whole cycles from the drive point. It checks each result at the falling edge just before its due edge (old value expected) and at the one just after (new value expected), so an off-by-one in either guard or in the settling delay shows as a mismatch.

// File: rtl/dtmf_steer_pkg.sv
package dtmf_steer_pkg;

    localparam int IDX_W  = 2;
    localparam int CODE_W = 4;
    localparam int GRID   = 1 << IDX_W;
    localparam int ALPHA_COL = GRID - 1;

    typedef logic [IDX_W-1:0]  tone_idx_t;
    typedef logic [CODE_W-1:0] key_code_t;

    // Key grid: rows 0..2 by columns 0..2 hold digits 1..9,
    // row 3 holds * 0 #, column 3 holds the letter keys.
    function automatic key_code_t grid_code(input int r, input int c);
        int v;
        if (c == ALPHA_COL) begin
            v = (r == GRID - 1) ? 0 : 13 + r;
        end else if (r == GRID - 1) begin
            v = (c == 0) ? 11 : ((c == 1) ? 10 : 12);
        end else begin
            v = r * 3 + c + 1;
        end
        return key_code_t'(v);
    endfunction

endpackage

// File: rtl/dtmf_keymap.sv
module dtmf_keymap
    import dtmf_steer_pkg::*;
(
    input  tone_idx_t row_i,
    input  tone_idx_t col_i,
    output key_code_t code_o,
    output logic      alpha_o
);

    key_code_t lut [GRID*GRID];

    for (genvar r = 0; r < GRID; r++) begin : g_row
        for (genvar c = 0; c < GRID; c++) begin : g_col
            assign lut[r*GRID + c] = grid_code(r, c);
        end
    end

    assign code_o  = lut[{row_i, col_i}];
    assign alpha_o = (col_i == tone_idx_t'(ALPHA_COL));

endmodule

// File: rtl/dtmf_guard.sv
module dtmf_guard #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pd_i,
    input  logic             early_i,
    input  logic             blocked_i,
    input  logic [CNT_W-1:0] acq_lim_i,
    input  logic [CNT_W-1:0] pause_lim_i,
    output logic             fire_o,
    output logic             drop_o,
    output logic             held_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             held;
    } guard_t;

    guard_t st_q, st_d;
    logic [CNT_W-1:0] acq_eff, pause_eff;

    assign acq_eff   = (acq_lim_i   == '0) ? ONE : acq_lim_i;
    assign pause_eff = (pause_lim_i == '0) ? ONE : pause_lim_i;

    always_comb begin
        st_d   = st_q;
        fire_o = 1'b0;
        drop_o = 1'b0;
        if (pd_i) begin
            st_d = '0;
        end else if (!st_q.held) begin
            if (early_i) begin
                if (st_q.cnt >= acq_eff - ONE) begin
                    if (!blocked_i) begin
                        fire_o      = 1'b1;
                        st_d.held   = 1'b1;
                        st_d.cnt    = pause_eff;
                    end
                end else begin
                    st_d.cnt = st_q.cnt + ONE;
                end
            end else if (st_q.cnt != '0) begin
                st_d.cnt = st_q.cnt - ONE;
            end
        end else begin
            if (early_i) begin
                st_d.cnt = (st_q.cnt < pause_eff) ? st_q.cnt + ONE : pause_eff;
            end else if (st_q.cnt <= ONE) begin
                drop_o    = 1'b1;
                st_d.held = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign held_o = st_q.held;

endmodule

// File: rtl/dtmf_latch.sv
module dtmf_latch
    import dtmf_steer_pkg::*;
#(
    parameter int SETTLE = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pd_i,
    input  logic      fire_i,
    input  logic      drop_i,
    input  key_code_t code_i,
    output key_code_t code_o,
    output logic      std_o
);

    localparam int DLY_W = $clog2(SETTLE + 1);
    localparam logic [DLY_W-1:0] DLY_ONE  = DLY_W'(1);
    localparam logic [DLY_W-1:0] DLY_LOAD = DLY_W'(SETTLE);

    typedef struct packed {
        key_code_t        code;
        logic [DLY_W-1:0] dly;
        logic             std;
    } latch_t;

    latch_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (pd_i || drop_i) begin
            st_d.dly = '0;
            st_d.std = 1'b0;
        end else if (fire_i) begin
            st_d.code = code_i;
            st_d.dly  = DLY_LOAD;
            st_d.std  = 1'b0;
        end else if (st_q.dly != '0) begin
            st_d.dly = st_q.dly - DLY_ONE;
            if (st_q.dly == DLY_ONE) st_d.std = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign code_o = st_q.code;
    assign std_o  = st_q.std;

endmodule

// File: rtl/dtmf_steer.sv
module dtmf_steer
    import dtmf_steer_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int SETTLE = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_down_i,
    input  logic             early_i,
    input  logic [1:0]       row_i,
    input  logic [1:0]       col_i,
    input  logic             inhibit_i,
    input  logic [CNT_W-1:0] acq_lim_i,
    input  logic [CNT_W-1:0] pause_lim_i,
    input  logic             out_en_i,
    output logic [3:0]       q_o,
    output logic             q_oe_o,
    output logic             std_o
);

    key_code_t map_code_w, code_w;
    logic      alpha_w, fire_w, drop_w, held_w;

    dtmf_keymap i_keymap (
        .row_i   (row_i),
        .col_i   (col_i),
        .code_o  (map_code_w),
        .alpha_o (alpha_w)
    );

    dtmf_guard #(.CNT_W(CNT_W)) i_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .pd_i        (pwr_down_i),
        .early_i     (early_i),
        .blocked_i   (inhibit_i & alpha_w),
        .acq_lim_i   (acq_lim_i),
        .pause_lim_i (pause_lim_i),
        .fire_o      (fire_w),
        .drop_o      (drop_w),
        .held_o      (held_w)
    );

    dtmf_latch #(.SETTLE(SETTLE)) i_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .pd_i   (pwr_down_i),
        .fire_i (fire_w),
        .drop_i (drop_w),
        .code_i (map_code_w),
        .code_o (code_w),
        .std_o  (std_o)
    );

    assign q_oe_o = out_en_i;
    assign q_o    = out_en_i ? code_w : '0;

endmodule

// File: rtl/dtmf_steer_chk.sv
module dtmf_steer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pwr_down_i,
    input logic       early_i,
    input logic       inhibit_i,
    input logic [1:0] col_i,
    input logic       std_o,
    input logic       fire_w,
    input logic       drop_w,
    input logic       held_w,
    input logic [3:0] code_w
);

    // R1
    fire_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_w |-> (early_i && !pwr_down_i));

    // R4
    std_not_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_w |=> !std_o);

    // R4
    std_rise_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(std_o) |-> (held_w && $stable(code_w)));

    // R5
    std_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(std_o) |-> ($past(drop_w) || $past(pwr_down_i)));

    // R3
    drop_only_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop_w |-> (held_w && !early_i));

    // R7
    inhibit_keeps_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit_i && col_i == 2'd3) |=> $stable(code_w));

    // R9
    pd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down_i |=> (!std_o && !held_w));

endmodule

bind dtmf_steer dtmf_steer_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_down_i (pwr_down_i),
    .early_i    (early_i),
    .inhibit_i  (inhibit_i),
    .col_i      (col_i),
    .std_o      (std_o),
    .fire_w     (fire_w),
    .drop_w     (drop_w),
    .held_w     (held_w),
    .code_w     (code_w)
);

// File: tb/test_dtmf_steer.sv
module test_dtmf_steer;

    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n, pwr_down, early, inhibit, out_en;
    logic [1:0]    row, col;
    logic [CW-1:0] acq_lim, pause_lim;
    logic [3:0]    q;
    logic          q_oe, std;

    int   checks = 0;
    int   errors = 0;
    bit   done = 0;
    logic [3:0] last_code = 4'd0;

    always #5 clk = ~clk;

    dtmf_steer #(.CNT_W(CW), .SETTLE(2)) i_dtmf_steer (
        .clk(clk), .rst_n(rst_n), .pwr_down_i(pwr_down), .early_i(early),
        .row_i(row), .col_i(col), .inhibit_i(inhibit),
        .acq_lim_i(acq_lim), .pause_lim_i(pause_lim), .out_en_i(out_en),
        .q_o(q), .q_oe_o(q_oe), .std_o(std)
    );

    // R6 key grid encoding
    function automatic logic [3:0] exp_code(input int r, input int c);
        int v;
        if (c == 3)      v = (r == 3) ? 0 : 13 + r;
        else if (r == 3) v = (c == 0) ? 11 : ((c == 1) ? 10 : 12);
        else             v = r * 3 + c + 1;
        return 4'(v);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rest();
        early = 1'b0;
        tick(40);
    endtask

    task automatic press_key(input int r, input int c);
        bit blk;
        int a, p;
        blk = inhibit && (c == 3);
        a = (acq_lim == 0) ? 1 : int'(acq_lim);
        p = (pause_lim == 0) ? 1 : int'(pause_lim);
        early = 1'b1; row = 2'(r); col = 2'(c);
        tick(a - 1);
        chk("R1 code before limit", q, last_code);
        chk("R1 strobe before limit", std, 0);
        tick(1);
        if (!blk) last_code = exp_code(r, c);
        chk(blk ? "R7 code kept" : "R6 code", q, last_code);
        chk("R4 strobe low at write", std, 0);
        tick(1);
        chk("R4 strobe low one after", std, 0);
        tick(1);
        chk(blk ? "R7 no strobe" : "R4 strobe two after", std, blk ? 0 : 1);
        early = 1'b0;
        if (!blk) begin
            tick(p - 1);
            chk("R3 held before pause limit", std, 1);
            tick(1);
            chk("R5 release", std, 0);
        end
        rest();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; pwr_down = 1'b0; early = 1'b0; inhibit = 1'b0;
        out_en = 1'b1; row = '0; col = '0; acq_lim = 8'd3; pause_lim = 8'd2;
        tick(3);
        chk("R8 reset code", q, 0);
        chk("R4 reset strobe", std, 0);
        chk("R8 reset enable", q_oe, 1);
        rst_n = 1'b1;
        tick(2);

        // R6 R7: all keys, inhibit off then on
        for (int inh = 0; inh < 2; inh++) begin
            inhibit = inh[0];
            for (int r = 0; r < 4; r++)
                for (int c = 0; c < 4; c++)
                    press_key(r, c);
        end
        inhibit = 1'b0;

        // R1 R5: limit sweep with a rejected short tone before each press
        for (int a = 0; a < 7; a++) begin
            acq_lim = 8'(a);
            pause_lim = 8'(a % 4);
            if (a >= 2) begin
                early = 1'b1; row = 2'd3; col = 2'(a % 3);
                tick(a - 1);
                early = 1'b0;
                tick(a + 3);
                chk("R1 short tone rejected", q, last_code);
                chk("R1 short tone no strobe", std, 0);
                rest();
            end
            press_key(3, a % 3);
            press_key(a % 3, 1);
        end

        // R2: 3 high, 1 low, 2 high with limit 4
        acq_lim = 8'd4; pause_lim = 8'd2;
        early = 1'b1; row = 2'd1; col = 2'd2;
        tick(3);
        early = 1'b0; tick(1);
        early = 1'b1; tick(1);
        chk("R2 not yet after dip", q, last_code);
        tick(1);
        last_code = exp_code(1, 2);
        chk("R2 accepted after dip", q, last_code);
        rest();

        // R3: tolerated dropout and no re-registration while held
        acq_lim = 8'd3; pause_lim = 8'd3;
        early = 1'b1; row = 2'd0; col = 2'd0;
        tick(5);
        last_code = exp_code(0, 0);
        chk("R3 setup code", q, last_code);
        chk("R3 setup strobe", std, 1);
        early = 1'b0; tick(2);
        chk("R3 short dropout", std, 1);
        early = 1'b1; row = 2'd1; col = 2'd1; tick(4);
        chk("R3 no second digit", q, last_code);
        chk("R3 strobe stays", std, 1);
        early = 1'b0; tick(2);
        chk("R5 before pause limit", std, 1);
        tick(1);
        chk("R5 at pause limit", std, 0);
        rest();

        // R8: bus gating
        out_en = 1'b0; #1;
        chk("R8 bus zero", q, 0);
        chk("R8 enable low", q_oe, 0);
        out_en = 1'b1; #1;
        chk("R8 bus code", q, last_code);
        chk("R8 enable high", q_oe, 1);
        tick(1);

        // R9: power-down
        acq_lim = 8'd3; pause_lim = 8'd2;
        early = 1'b1; row = 2'd2; col = 2'd2;
        tick(5);
        last_code = exp_code(2, 2);
        chk("R9 setup strobe", std, 1);
        pwr_down = 1'b1; tick(1);
        chk("R9 strobe cleared", std, 0);
        row = 2'd0; col = 2'd1; tick(6);
        chk("R9 no accept in power-down", q, last_code);
        chk("R9 strobe stays low", std, 0);
        pwr_down = 1'b0; tick(2);
        chk("R9 full guard after release", q, last_code);
        tick(1);
        last_code = exp_code(0, 1);
        chk("R9 accept after release", q, last_code);
        tick(2);
        chk("R9 strobe after release", std, 1);
        rest();

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule